// File: doc/BRIEF.md
# I2C SCL Waveform Generator

This block produces the serial clock pattern of an I2C master from a fast system clock. Software loads one waveform word holding a power-of-two prescale exponent and two 8-bit dividers, one for the low half of the SCL period and one for the high half. Each half lasts the divider shifted left by the exponent, plus a fixed number of system clocks set by a parameter. Equal dividers give a symmetric clock. Unequal dividers give an asymmetric one.

Alongside the SCL level, the generator emits three one-cycle strobes for a transaction sequencer. One marks the start of each low phase and one marks the start of each high phase. The third marks the middle of the low phase, which is where the sequencer changes SDA. A newly written word is held in a shadow register and is taken up only when a low phase begins, so a write never cuts a phase short. While the generator is disabled, SCL is released high and its counter stays cleared.

Top module: `scl_wavegen`

## Requirements
- R1: After reset, `scl_o` is 1 and all three strobes are 0. The waveform word resets to exponent 0 with both dividers 0, so a first enable gives halves of OFFSET clocks each.
- R2: While `en` is 0, `scl_o` is 1 from the next cycle on and no strobe is asserted. The half-period counter is cleared, so a later enable starts a full-length low phase.
- R3: The waveform word places the exponent in bits [18:16], the high divider in bits [15:8] and the low divider in bits [7:0]. Bits [31:19] have no effect.
- R4: Each low phase lasts `lo * 2^exp + OFFSET` system clocks, measured as the number of cycles in which `scl_o` is 0.
- R5: Each high phase lasts `hi * 2^exp + OFFSET` system clocks, measured as the number of cycles in which `scl_o` is 1 between two low phases.
- R6: A written exponent above MAX_EXP is stored as MAX_EXP, and both dividers are then stored as 255. The value in the rest of the word does not matter.
- R7: A word written during a low phase changes neither that low phase nor the high phase after it. It takes effect at the start of the next low phase.
- R8: `low_start_o` is high for exactly the first cycle of each low phase, which is the cycle in which `scl_o` falls. `high_start_o` is high for exactly the first cycle of each high phase. No two strobes are ever high together.
- R9: `low_mid_o` is high for one cycle per low phase. Counting the first low cycle as index 0, it is high at index floor(L/2), where L is the low-phase length.
- R10: `scl_o` falls, and `low_start_o` rises, at the first rising clock edge that samples `en` as 1 while the generator is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable |
| cfg_we | input | 1 | Write strobe for the waveform word |
| cfg_wdata | input | DATA_W | Waveform word: exponent [18:16], high divider [15:8], low divider [7:0] |
| scl_o | output | 1 | SCL level: 0 drives the line low, 1 releases it |
| low_start_o | output | 1 | One-cycle strobe on the first cycle of a low phase |
| high_start_o | output | 1 | One-cycle strobe on the first cycle of a high phase |
| low_mid_o | output | 1 | One-cycle strobe in the middle of a low phase |

## Verification
`scl_o` and every strobe are registered at the same edge that advances the phase state. An enable therefore shows up at the first edge that samples it. A write lands in the shadow register one edge after `cfg_we`, and it reaches the waveform only at the edge that opens the next low phase. The bench drives inputs and samples outputs one time unit after each rising edge. It measures each phase by counting samples of a constant `scl_o` level from the `low_start_o` or `high_start_o` sample onward, and it records the index of the middle strobe within the low phase. Mid-run tests place their write or disable at a known sample inside the phase, and then check the current phase, the next phase and the one after that separately.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  localparam int EXP_W  = 3;
  localparam int DIV_W  = 8;
  localparam int LO_LSB = 0;
  localparam int HI_LSB = 8;
  localparam int EX_LSB = 16;
  localparam int FIELD_TOP = EX_LSB + EXP_W - 1;

  typedef struct packed {
    logic [EXP_W-1:0] exp;
    logic [DIV_W-1:0] hi;
    logic [DIV_W-1:0] lo;
  } wave_cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/sclgen_cfg_shadow.sv
module sclgen_cfg_shadow
  import sclgen_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MAX_EXP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output wave_cfg_t         pend_o
);
  wave_cfg_t raw;
  wave_cfg_t capped;
  wave_cfg_t pend_q;
  logic      unused_upper;

  assign raw.exp = wdata[EX_LSB +: EXP_W];
  assign raw.hi  = wdata[HI_LSB +: DIV_W];
  assign raw.lo  = wdata[LO_LSB +: DIV_W];
  assign unused_upper = ^wdata[DATA_W-1:FIELD_TOP+1];

  generate
    if (MAX_EXP < (1 << EXP_W) - 1) begin : g_sat
      always_comb begin
        capped = raw;
        if (raw.exp > EXP_W'(MAX_EXP)) begin
          capped.exp = EXP_W'(MAX_EXP);
          capped.hi  = '1;
          capped.lo  = '1;
        end
      end
    end else begin : g_nosat
      always_comb capped = raw;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     pend_q <= '0;
    else if (we) pend_q <= capped;
  end

  assign pend_o = pend_q;

  AST_EXP_CAPPED: assert property (@(posedge clk) disable iff (rst)
    pend_q.exp <= EXP_W'(MAX_EXP)); // R6

  AST_SAT_DIVS: assert property (@(posedge clk) disable iff (rst)
    (we && (wdata[EX_LSB +: EXP_W] > EXP_W'(MAX_EXP)))
      |=> (pend_q.hi == '1 && pend_q.lo == '1)); // R6
endmodule

// File: rtl/sclgen_half_timer.sv
module sclgen_half_timer
  import sclgen_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 5,
  parameter int CNT_W   = DIV_W + MAX_EXP + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  wave_cfg_t        pend_i,
  output phase_e           ph_q_o,
  output phase_e           ph_n_o,
  output logic [CNT_W-1:0] cnt_n_o,
  output logic [CNT_W-1:0] low_len_n_o
);
  phase_e           ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  wave_cfg_t        act_q, act_n;
  logic             load;
  logic [CNT_W-1:0] low_len, high_len;

  function automatic logic [CNT_W-1:0] half_len(input logic [DIV_W-1:0] d,
                                                input logic [EXP_W-1:0] e);
    return (CNT_W'(d) << e) + CNT_W'(OFFSET);
  endfunction

  assign low_len  = half_len(act_q.lo, act_q.exp);
  assign high_len = half_len(act_q.hi, act_q.exp);

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q + 1'b1;
    load  = 1'b0;
    if (!en) begin
      ph_n  = PH_IDLE;
      cnt_n = '0;
      load  = 1'b1;
    end else begin
      unique case (ph_q)
        PH_LOW: begin
          if (cnt_q == low_len - 1'b1) begin
            ph_n  = PH_HIGH;
            cnt_n = '0;
          end
        end
        PH_HIGH: begin
          if (cnt_q == high_len - 1'b1) begin
            ph_n  = PH_LOW;
            cnt_n = '0;
            load  = 1'b1;
          end
        end
        default: begin
          ph_n  = PH_LOW;
          cnt_n = '0;
          load  = 1'b1;
        end
      endcase
    end
    act_n = load ? pend_i : act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end

  assign ph_q_o      = ph_q;
  assign ph_n_o      = ph_n;
  assign cnt_n_o     = cnt_n;
  assign low_len_n_o = half_len(act_n.lo, act_n.exp);

  AST_LOW_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_LOW) |-> (cnt_q < low_len)); // R4

  AST_HIGH_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_HIGH) |-> (cnt_q < high_len)); // R5

  AST_CFG_HELD_MIDRUN: assert property (@(posedge clk) disable iff (rst)
    ((ph_q == PH_HIGH) || (ph_q == PH_LOW && cnt_q != '0)) |-> $stable(act_q)); // R7

  AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE) |-> (cnt_q == '0)); // R2
endmodule

// File: rtl/sclgen_out_stage.sv
module sclgen_out_stage
  import sclgen_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  phase_e           ph_q_i,
  input  phase_e           ph_n_i,
  input  logic [CNT_W-1:0] cnt_n_i,
  input  logic [CNT_W-1:0] low_len_n_i,
  output logic             scl_o,
  output logic             low_start_o,
  output logic             high_start_o,
  output logic             low_mid_o
);
  logic scl_n, ls_n, hs_n, mid_n;

  always_comb begin
    scl_n = (ph_n_i != PH_LOW);
    ls_n  = (ph_n_i == PH_LOW)  && (ph_q_i != PH_LOW);
    hs_n  = (ph_n_i == PH_HIGH) && (ph_q_i != PH_HIGH);
    mid_n = (ph_n_i == PH_LOW)  && (cnt_n_i == (low_len_n_i >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_o        <= 1'b1;
      low_start_o  <= 1'b0;
      high_start_o <= 1'b0;
      low_mid_o    <= 1'b0;
    end else begin
      scl_o        <= scl_n;
      low_start_o  <= ls_n;
      high_start_o <= hs_n;
      low_mid_o    <= mid_n;
    end
  end

  AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_o && !low_start_o && !high_start_o && !low_mid_o)); // R2

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({low_start_o, high_start_o, low_mid_o})); // R8

  AST_FALL_MARKED: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_o) |-> low_start_o); // R8

  AST_HIGH_START_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    high_start_o |-> $rose(scl_o)); // R8

  AST_MID_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    low_mid_o |-> !scl_o); // R9
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import sclgen_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              scl_o,
  output logic              low_start_o,
  output logic              high_start_o,
  output logic              low_mid_o
);
  localparam int CNT_W = DIV_W + MAX_EXP + 1;

  wave_cfg_t        pend;
  phase_e           ph_q, ph_n;
  logic [CNT_W-1:0] cnt_n, low_len_n;

  sclgen_cfg_shadow #(
    .DATA_W (DATA_W),
    .MAX_EXP(MAX_EXP)
  ) u_shadow (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .pend_o(pend)
  );

  sclgen_half_timer #(
    .OFFSET (OFFSET),
    .MAX_EXP(MAX_EXP),
    .CNT_W  (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .pend_i     (pend),
    .ph_q_o     (ph_q),
    .ph_n_o     (ph_n),
    .cnt_n_o    (cnt_n),
    .low_len_n_o(low_len_n)
  );

  sclgen_out_stage #(
    .CNT_W(CNT_W)
  ) u_out (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .ph_q_i      (ph_q),
    .ph_n_i      (ph_n),
    .cnt_n_i     (cnt_n),
    .low_len_n_i (low_len_n),
    .scl_o       (scl_o),
    .low_start_o (low_start_o),
    .high_start_o(high_start_o),
    .low_mid_o   (low_mid_o)
  );
endmodule

// File: tb/scl_wavegen_bench.sv
module scl_wavegen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OFFSET     = 4;
  localparam int MAX_EXP    = 5;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 7;

  // waveform word, expected low length, high length, mid index
  localparam logic [31:0] VEC_CFG [NVEC] = '{
    32'h0000_0000, 32'h0000_0505, 32'h0002_0703, 32'h0005_0201,
    32'h0006_0101, 32'hFF07_1234, 32'hFFF9_000A };
  localparam int VEC_LO  [NVEC] = '{4, 9, 16, 36, 8164, 8164, 24};
  localparam int VEC_HI  [NVEC] = '{4, 9, 32, 68, 8164, 8164, 4};
  localparam int VEC_MID [NVEC] = '{2, 4, 8, 18, 4082, 4082, 12};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        scl_o, low_start_o, high_start_o, low_mid_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_wavegen #(.DATA_W(32), .OFFSET(OFFSET), .MAX_EXP(MAX_EXP)) u_scl_wavegen (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .scl_o(scl_o), .low_start_o(low_start_o), .high_start_o(high_start_o),
    .low_mid_o(low_mid_o));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts on the first low sample; ends on the next low_start sample.
  task automatic measure(output int lo, output int hi, output int mid, output int bad);
    lo = 0; hi = 0; mid = -1; bad = 0;
    while (scl_o == 1'b0 && lo < 20000) begin
      if (low_mid_o) begin
        if (mid != -1) bad++;
        mid = lo;
      end
      if (lo > 0 && low_start_o) bad++;
      if (high_start_o) bad++;
      lo++;
      step();
    end
    if (!high_start_o) bad++;
    while (scl_o == 1'b1 && hi < 20000) begin
      if (hi > 0 && high_start_o) bad++;
      if (low_start_o || low_mid_o) bad++;
      hi++;
      step();
    end
    if (!low_start_o) bad++;
  endtask

  task automatic load_and_enable(input logic [31:0] w);
    en = 1'b0;
    step();
    cfg_we = 1'b1;
    cfg_wdata = w;
    step();
    cfg_we = 1'b0;
    en = 1'b1;
    step();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected 0 cycles left", 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lo, hi, mid, bad;
    step();
    step();
    rst = 1'b0;
    step();
    // R1: outputs at rest after reset
    check("R1 scl", int'(scl_o), 1);
    check("R1 strobes", int'({low_start_o, high_start_o, low_mid_o}), 0);
    // R1 / R10: enabling with the reset word gives OFFSET-long halves
    en = 1'b1;
    step();
    check("R10 scl falls at first enable edge", int'(scl_o), 0);
    check("R10 low_start on first edge", int'(low_start_o), 1);
    measure(lo, hi, mid, bad);
    check("R1 reset word low", lo, OFFSET);
    check("R1 reset word high", hi, OFFSET);

    // Table walk: R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      load_and_enable(VEC_CFG[i]);
      check("R10 start", int'(low_start_o), 1);
      measure(lo, hi, mid, bad);
      check("R4 low length", lo, VEC_LO[i]);
      check("R5 high length", hi, VEC_HI[i]);
      check("R9 mid index", mid, VEC_MID[i]);
      check("R8 strobe placement", bad, 0);
      if (i >= 4 && i <= 5) check("R6 saturated low", lo, 255 * 32 + OFFSET);
      if (i >= 5) check("R3 upper bits ignored", lo + hi, VEC_LO[i] + VEC_HI[i]);
    end

    // R7: a write in mid-low waits for the next low phase
    load_and_enable(32'h0000_0505);
    step();
    step();
    cfg_we = 1'b1;
    cfg_wdata = 32'h0000_0101;
    step();
    cfg_we = 1'b0;
    lo = 3;
    while (scl_o == 1'b0 && lo < 100) begin lo++; step(); end
    check("R7 current low unchanged", lo, 9);
    hi = 0;
    while (scl_o == 1'b1 && hi < 100) begin hi++; step(); end
    check("R7 following high unchanged", hi, 9);
    measure(lo, hi, mid, bad);
    check("R7 next low uses new word", lo, 5);
    check("R7 next high uses new word", hi, 5);

    // R2: disable in mid-low, stay released, restart with full low
    load_and_enable(32'h0005_0201);
    repeat (10) step();
    en = 1'b0;
    step();
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      if (!scl_o || low_start_o || high_start_o || low_mid_o) bad++;
      step();
    end
    check("R2 released while disabled", bad, 0);
    en = 1'b1;
    step();
    check("R2 restart low_start", int'(low_start_o), 1);
    measure(lo, hi, mid, bad);
    check("R2 restart full low", lo, 36);
    check("R2 restart high", hi, 68);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule